// File: doc/BRIEF.md
# Ring interrupt status aggregator

This block gathers per-hop event pulses from a set of transmit and receive rings and turns them into a single interrupt line. There are three kinds of event: transmit done, receive done and receive overflow. Each one sets a sticky pending bit. Software reads the pending bits through 32-bit status words that clear themselves on read. Two per-hop enable vectors decide which pending bits may raise the interrupt. A read-only word reports how many hops the instance supports.

Once the interrupt pulses, the block holds it back until software has read every status word at least once. That includes words whose bits all belong to disabled rings. A driver therefore has to sweep the whole status set before it can be interrupted again.

Register access uses a plain single-cycle port. Read data is combinational from the address in the same cycle as the read strobe. A status read clears its word at the clock edge that ends that cycle.

Top module: `ringirq_top`

## Requirements
- R1: Pending bits are packed with transmit-done of hop h at bit h, receive-done of hop h at bit HOPS+h and overflow of hop h at bit 2*HOPS+h. Status word w sits at address w and holds bits 32w..32w+31. There are (31+3*HOPS)/32 status words, and bits at 3*HOPS and above read as zero.
- R2: A read of a status word returns its pending bits and clears them to zero at the end of that cycle.
- R3: An event that arrives in the same cycle as a clearing read of its word survives and reads as 1 on the next read.
- R4: Enable bits are packed with receive of hop h at bit h and transmit of hop h at bit HOPS+h. Enable word w sits at address ENB_BASE+w, and there are (31+2*HOPS)/32 enable words. Written bits read back as written, and bits at 2*HOPS and above read zero.
- R5: The interrupt output is a pulse exactly one cycle wide.
- R6: After a pulse, no further pulse occurs until every status word has been read since that pulse. Once the sweep completes, a pulse follows within two cycles if an enabled bit is pending.
- R7: An overflow bit raises the interrupt only through the receive enable of the same hop. The transmit enable has no effect on it.
- R8: A pending bit whose enable is clear raises no interrupt but still reads back as 1.
- R9: A read at HOP_ADDR returns HOPS in bits 10:0, with the upper bits zero.
- R10: After reset all pending and enable bits are zero, the interrupt is low and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDone | input | HOPS | Per-hop transmit-done event pulses |
| rxDone | input | HOPS | Per-hop receive-done event pulses |
| rxOvf | input | HOPS | Per-hop receive-overflow event pulses |
| regAddr | input | ADDR_W | Register word address |
| regRdEn | input | 1 | Read strobe (clears an addressed status word) |
| regWrEn | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets five corner cases, each of which shows a particular fault:
- An event that lands in the cycle of its word's clearing read. A design that lets the clear win silently loses an event.
- Overflow on a hop that has only its transmit enable set, and later only its receive enable set. A design with the enable mapping crossed fires on the wrong one.
- Reading just one of the two status words after a pulse. A re-arm that counts reads instead of tracking every word interrupts again too early.
- Bits beyond the packed fields, which must read as zero. A design that reads stray enable bits returns junk there.
- Random traffic, which shows up a pulse wider than one cycle.

// File: rtl/ringirq_pkg.sv
package ringirq_pkg;
  localparam int MAX_WORDS = 8;
  localparam int IDX_W = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {SEL_NONE, SEL_STS, SEL_ENB, SEL_HOP} rdsel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic [MAX_WORDS-1:0] stsClr;
    logic [MAX_WORDS-1:0] enbWr;
    rdsel_e               rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } strobe_t;
endpackage

// File: rtl/ringirq_ctrl.sv
module ringirq_ctrl
  import ringirq_pkg::*;
#(
  parameter int HOPS     = 20,
  parameter int ADDR_W   = 6,
  parameter int ENB_BASE = 16,
  parameter int HOP_ADDR = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic              anyEnPend,
  output strobe_t           stb,
  output logic              irq
);
  localparam int NSTS = (31 + 3 * HOPS) / 32;
  localparam int NENB = (31 + 2 * HOPS) / 32;
  localparam logic [ADDR_W-1:0] STS_END = ADDR_W'(NSTS);
  localparam logic [ADDR_W-1:0] ENB_LO  = ADDR_W'(ENB_BASE);
  localparam logic [ADDR_W-1:0] ENB_END = ADDR_W'(ENB_BASE + NENB);
  localparam logic [ADDR_W-1:0] HOP_A   = ADDR_W'(HOP_ADDR);

  logic [ADDR_W-1:0] enbOff;
  logic              armed;
  logic [NSTS-1:0]   sweep;
  logic              fire;

  assign enbOff = regAddr - ENB_LO;

  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    if (regAddr < STS_END) begin
      stb.rdSel = SEL_STS;
      stb.rdIdx = regAddr[IDX_W-1:0];
      stb.stsClr[regAddr[IDX_W-1:0]] = regRdEn;
    end else if (regAddr >= ENB_LO && regAddr < ENB_END) begin
      stb.rdSel = SEL_ENB;
      stb.rdIdx = enbOff[IDX_W-1:0];
      stb.enbWr[enbOff[IDX_W-1:0]] = regWrEn;
    end else if (regAddr == HOP_A) begin
      stb.rdSel = SEL_HOP;
    end
  end

  assign fire = armed && anyEnPend;

  // re-arm flag: dropped on a pulse, restored after a full read sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
      sweep <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) begin
        armed <= 1'b0;
        sweep <= '0;
      end else if (!armed && (&sweep)) begin
        armed <= 1'b1;
        sweep <= '0;
      end else begin
        sweep <= sweep | stb.stsClr[NSTS-1:0];
      end
    end
  end
endmodule

// File: rtl/ringirq_dp.sv
module ringirq_dp
  import ringirq_pkg::*;
#(
  parameter int HOPS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOPS-1:0]   txDone,
  input  logic [HOPS-1:0]   rxDone,
  input  logic [HOPS-1:0]   rxOvf,
  input  strobe_t           stb,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              anyEnPend,
  output logic [3*HOPS-1:0] pendVec
);
  localparam int SB   = 3 * HOPS;
  localparam int EB   = 2 * HOPS;
  localparam int NSTS = (31 + SB) / 32;
  localparam int NENB = (31 + EB) / 32;

  logic [SB-1:0]      pend, clrBits, pendNext, enX;
  logic [EB-1:0]      en, enNext;
  logic [NSTS*32-1:0] pendPad;
  logic [NENB*32-1:0] enPad;
  logic [31:0]        stsWord [NSTS];
  logic [31:0]        enbWord [NENB];

  for (genvar b = 0; b < SB; b++) begin : g_clr
    assign clrBits[b] = stb.stsClr[b / 32];
  end
  for (genvar b = 0; b < EB; b++) begin : g_wr
    assign enNext[b] = stb.enbWr[b / 32] ? wdata[b % 32] : en[b];
  end

  assign pendNext = (pend & ~clrBits) | {rxOvf, rxDone, txDone};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= pendNext;
      en   <= enNext;
    end
  end

  // overflow follows the receive enable of its hop
  assign enX = {en[HOPS-1:0], en[HOPS-1:0], en[EB-1:HOPS]};
  assign anyEnPend = |(pend & enX);
  assign pendVec = pend;

  always_comb begin
    pendPad = '0;
    pendPad[SB-1:0] = pend;
    enPad = '0;
    enPad[EB-1:0] = en;
  end

  for (genvar w = 0; w < NSTS; w++) begin : g_sw
    assign stsWord[w] = pendPad[w*32 +: 32];
  end
  for (genvar w = 0; w < NENB; w++) begin : g_ew
    assign enbWord[w] = enPad[w*32 +: 32];
  end

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      SEL_STS: for (int w = 0; w < NSTS; w++)
                 if (stb.rdIdx == w[IDX_W-1:0]) rdata = stsWord[w];
      SEL_ENB: for (int w = 0; w < NENB; w++)
                 if (stb.rdIdx == w[IDX_W-1:0]) rdata = enbWord[w];
      SEL_HOP: rdata = {21'd0, 11'(HOPS)};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ringirq_top.sv
module ringirq_top
  import ringirq_pkg::*;
#(
  parameter int HOPS     = 20,
  parameter int ADDR_W   = 6,
  parameter int ENB_BASE = 16,
  parameter int HOP_ADDR = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOPS-1:0]   txDone,
  input  logic [HOPS-1:0]   rxDone,
  input  logic [HOPS-1:0]   rxOvf,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  strobe_t             stb;
  logic                anyEnPend;
  logic [3*HOPS-1:0]   pendVec;

  ringirq_ctrl #(
    .HOPS(HOPS), .ADDR_W(ADDR_W), .ENB_BASE(ENB_BASE), .HOP_ADDR(HOP_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .anyEnPend(anyEnPend), .stb(stb), .irq(irq)
  );

  ringirq_dp #(.HOPS(HOPS)) u_dp (
    .clk(clk), .rstN(rstN), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
    .stb(stb), .wdata(regWdata), .rdata(regRdata), .anyEnPend(anyEnPend),
    .pendVec(pendVec)
  );
endmodule

// File: rtl/ringirq_chk.sv
module ringirq_chk #(
  parameter int HOPS     = 20,
  parameter int ADDR_W   = 6,
  parameter int HOP_ADDR = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [HOPS-1:0]   txDone,
  input logic [HOPS-1:0]   rxDone,
  input logic [HOPS-1:0]   rxOvf,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRdEn,
  input logic [31:0]       regRdata,
  input logic              irq,
  input logic [3*HOPS-1:0] pendVec
);
  localparam int NSTS = (31 + 3 * HOPS) / 32;
  localparam int W0   = (3 * HOPS < 32) ? 3 * HOPS : 32;

  logic [NSTS-1:0] readsNow, seenMask;
  logic            seenIrq, fullFlag;

  for (genvar w = 0; w < NSTS; w++) begin : g_rd
    assign readsNow[w] = regRdEn && (regAddr == ADDR_W'(w));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenMask <= '0;
      seenIrq  <= 1'b0;
      fullFlag <= 1'b0;
    end else if (irq) begin
      seenIrq  <= 1'b1;
      seenMask <= readsNow;
      fullFlag <= &readsNow;
    end else begin
      seenMask <= seenMask | readsNow;
      if (&(seenMask | readsNow)) fullFlag <= 1'b1;
    end
  end

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_sweep_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && seenIrq) |-> fullFlag);

  p_event_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|txDone) |=> ((pendVec[HOPS-1:0] & $past(txDone)) == $past(txDone)));

  p_ovf_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|rxOvf) |=> ((pendVec[3*HOPS-1:2*HOPS] & $past(rxOvf)) == $past(rxOvf)));

  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (readsNow[0] && !(|txDone) && !(|rxDone) && !(|rxOvf)) |=> (pendVec[W0-1:0] == '0));

  p_hop_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(HOP_ADDR)) |-> (regRdata == 32'(HOPS)));
endmodule

bind ringirq_top ringirq_chk #(.HOPS(HOPS), .ADDR_W(ADDR_W), .HOP_ADDR(HOP_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
  .regAddr(regAddr), .regRdEn(regRdEn), .regRdata(regRdata), .irq(irq),
  .pendVec(pendVec)
);

// File: tb/tb_ringirq_top.sv
module tb_ringirq_top;
  localparam int HOPS = 20, ADDR_W = 6, ENB_BASE = 16, HOP_ADDR = 32;
  localparam int NSTS = (31 + 3 * HOPS) / 32;
  localparam int NENB = (31 + 2 * HOPS) / 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [HOPS-1:0] txDone = '0, rxDone = '0, rxOvf = '0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regRdEn = 1'b0, regWrEn = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq;

  ringirq_top #(.HOPS(HOPS), .ADDR_W(ADDR_W), .ENB_BASE(ENB_BASE), .HOP_ADDR(HOP_ADDR)) dut (
    .clk(clk), .rstN(rstN), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq));

  always #4 clk = ~clk;  // 125 MHz

  int nVec = 0, nBad = 0, pulses = 0, wide = 0;
  logic prevIrq = 1'b0;
  logic [31:0] lastRd;
  // expected-value state
  logic [3*HOPS-1:0] mPend = '0;
  logic [2*HOPS-1:0] mEn = '0;
  logic mArmed = 1'b1, mIrq = 1'b0;
  logic [NSTS-1:0] mMask = '0;

  function automatic logic [31:0] expRead(input int a);
    logic [63:0] p, e;
    p = '0; p[3*HOPS-1:0] = mPend;
    e = '0; e[2*HOPS-1:0] = mEn;
    if (a < NSTS) return p[a*32 +: 32];
    if (a >= ENB_BASE && a < ENB_BASE + NENB) return e[(a-ENB_BASE)*32 +: 32];
    if (a == HOP_ADDR) return 32'(HOPS);
    return 32'd0;
  endfunction

  function automatic logic expAny();
    return |(mPend & {mEn[HOPS-1:0], mEn[HOPS-1:0], mEn[2*HOPS-1:HOPS]});
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [HOPS-1:0] tx, input logic [HOPS-1:0] rx,
                     input logic [HOPS-1:0] ov, input logic rd, input logic wr,
                     input int a, input logic [31:0] wd, input string tag);
    logic fire;
    logic [63:0] clr, e;
    @(negedge clk);
    txDone = tx; rxDone = rx; rxOvf = ov;
    regRdEn = rd; regWrEn = wr; regAddr = ADDR_W'(a); regWdata = wd;
    #1;
    lastRd = regRdata;
    if (rd) check(regRdata, expRead(a), tag);
    @(posedge clk);
    fire = mArmed && expAny();
    clr = '0;
    if (rd && a < NSTS) clr[a*32 +: 32] = '1;
    if (fire) begin mArmed = 1'b0; mMask = '0; end
    else if (!mArmed && (&mMask)) begin mArmed = 1'b1; mMask = '0; end
    else if (rd && a < NSTS) mMask[a] = 1'b1;
    mIrq = fire;
    mPend = (mPend & ~clr[3*HOPS-1:0]) | {ov, rx, tx};
    if (wr && a >= ENB_BASE && a < ENB_BASE + NENB) begin
      e = '0; e[2*HOPS-1:0] = mEn;
      e[(a-ENB_BASE)*32 +: 32] = wd;
      mEn = e[2*HOPS-1:0];
    end
    #1;
    check({31'd0, irq}, {31'd0, mIrq}, tag);
    if (irq) pulses++;
    if (irq && prevIrq) wide++;
    prevIrq = irq;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc('0, '0, '0, 1'b0, 1'b0, 0, 32'd0, tag);
  endtask

  task automatic rdLit(input int a, input logic [31:0] exp, input string tag);
    cyc('0, '0, '0, 1'b1, 1'b0, a, 32'd0, tag);
    check(lastRd, exp, tag);
  endtask

  task automatic wrEn(input int a, input logic [31:0] d, input string tag);
    cyc('0, '0, '0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check({31'd0, irq}, 32'd0, "R10 irq low");
    // R10 reset state
    rdLit(0, 32'd0, "R10 status0");
    rdLit(1, 32'd0, "R10 status1");
    rdLit(16, 32'd0, "R10 enable0");
    rdLit(17, 32'd0, "R10 enable1");
    // R9 hop count
    rdLit(HOP_ADDR, 32'd20, "R9 hop count");
    // R4 enable readback and unused bits
    wrEn(16, 32'hFFFF_FFFF, "R4");
    wrEn(17, 32'hFFFF_FFFF, "R4");
    rdLit(17, 32'h0000_00FF, "R4 enable1 upper zero");
    rdLit(16, 32'hFFFF_FFFF, "R4 enable0");
    wrEn(16, 32'd0, "R4"); wrEn(17, 32'd0, "R4");
    rdLit(16, 32'd0, "R4 cleared");
    // R1 layout: tx hop3 bit3, rx hop15 bit35, ovf hop19 bit59
    cyc(20'h8, 20'h8000, 20'h80000, 1'b0, 1'b0, 0, 0, "R1");
    rdLit(0, 32'h0000_0008, "R1 word0");
    rdLit(1, 32'h0800_0008, "R1 word1");
    // R2 read clears
    rdLit(0, 32'd0, "R2 word0 after read");
    rdLit(1, 32'd0, "R2 word1 after read");
    // R3 event during clearing read
    cyc(20'h20, '0, '0, 1'b1, 1'b0, 0, 0, "R3");
    check(lastRd, 32'd0, "R3 same-cycle read");
    rdLit(0, 32'h0000_0020, "R3 event kept");
    // R8 disabled pending bit: rx hop2 = bit22
    cyc('0, 20'h4, '0, 1'b0, 1'b0, 0, 0, "R8");
    pulses = 0;
    idle(4, "R8");
    check(32'(pulses), 32'd0, "R8 no pulse while disabled");
    rdLit(0, 32'h0040_0000, "R8 still pending");
    // R7: overflow hop6 with only tx enable of hop6 (bit 26)
    wrEn(16, 32'h0400_0000, "R7");
    pulses = 0;
    cyc('0, '0, 20'h40, 1'b0, 1'b0, 0, 0, "R7");
    idle(4, "R7");
    check(32'(pulses), 32'd0, "R7 tx enable ignored by overflow");
    cyc(20'h40, '0, '0, 1'b0, 1'b0, 0, 0, "R7");
    idle(3, "R5");
    check(32'(pulses), 32'd1, "R5 tx event pulses once");
    rdLit(0, 32'h0000_0040, "R7 tx hop6 pending");
    rdLit(1, 32'h0000_4000, "R7 ovf hop6 pending");
    idle(2, "R6 rearm");
    // R7: overflow hop4 via rx enable hop4
    wrEn(16, 32'h0000_0010, "R7");
    pulses = 0;
    cyc('0, '0, 20'h10, 1'b0, 1'b0, 0, 0, "R7");
    idle(4, "R7");
    check(32'(pulses), 32'd1, "R7 rx enable passes overflow");
    // R6: sweep needed before re-fire
    rdLit(1, 32'h0000_1000, "R6 read word1");
    pulses = 0;
    cyc('0, '0, 20'h10, 1'b0, 1'b0, 0, 0, "R6");
    idle(6, "R6");
    check(32'(pulses), 32'd0, "R6 partial sweep holds irq");
    rdLit(0, 32'd0, "R6 read word0 (disabled bits only)");
    idle(3, "R6");
    check(32'(pulses), 32'd1, "R6 pulse after full sweep");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [HOPS-1:0] t, r, o;
      int sel, a;
      logic rd, wr;
      t = HOPS'($urandom & $urandom & $urandom & $urandom);
      r = HOPS'($urandom & $urandom & $urandom & $urandom);
      o = HOPS'($urandom & $urandom & $urandom & $urandom & $urandom);
      sel = int'($urandom % 8);
      a = (sel < 3) ? 0 : (sel < 5) ? 1 : (sel == 5) ? 16 + int'($urandom % 2)
          : (sel == 6) ? HOP_ADDR : int'($urandom % 64);
      rd = ($urandom % 3) != 0;
      wr = ($urandom % 10) == 0;
      cyc(t, r, o, rd, wr, a, $urandom, "R5 R6 R7 R2 random");
    end
    check(32'(wide), 32'd0, "R5 no pulse wider than one cycle");
    finishRun();
  end
endmodule